// File: doc/BRIEF.md
# AC97 Codec Register Access Engine

This block lets host software read and write the registers of an AC97 codec across a frame-level link model. The host loads the 16-bit write value into a slot-2 holding register and then writes the 7-bit codec register index into a slot-1 register. That second write launches the command. If slot 2 was not loaded since the previous command, the launch is a read. The next outgoing frame then carries the command in its slot-1 and slot-2 fields, with the matching tag bits set. For a read, the codec's reply is captured from incoming slot 2 and made available in the slot-2 register.

Completion, read-data arrival, codec readiness and a codec wake event each set a sticky bit in a raw status register. A mask register selects which of these bits drive the level-high interrupt output. The host acknowledges slot events by touching either slot register, and acknowledges readiness and wake through an end-of-interrupt register. A global enable starts and stops the link. Two self-timed pulse generators provide a cold reset to the codec and a warm-reset SYNC pulse.

Register offsets are fixed: slot 1 at 0x80, slot 2 at 0x84, raw status at 0x8C, masked status at 0x90, mask at 0x94, end-of-interrupt at 0x98, enable at 0x9C, cold reset at 0xA0 and warm sync at 0xA4. Read data appears on `bus_rdata_o` one cycle after the read access. Unmapped reads return 0.

Top module: `ac97_cmd_engine`

## Requirements
- R1: Writing slot 2 and then slot 1 causes the next frame to carry tag 16'hE000. Tag bit 15 marks the frame valid, bit 14 marks slot 1 valid and bit 13 marks slot 2 valid. In that frame, slot 1 holds read flag bit 19 = 0 and the index in bits 18:12, and slot 2 holds the data in bits 19:4.
- R2: A slot-1 write with no slot-2 write since the previous command causes the next frame to carry tag 16'hC000. In that frame, slot-1 bit 19 is 1, the index is in bits 18:12, and slot 2 is zero.
- R3: After a read frame is sent, the first incoming frame with tag bit 13 set loads its slot-2 bits 19:4 into the slot-2 register (0x84) and sets raw status bit 1. An incoming reply when no read is outstanding changes neither.
- R4: Raw status bit 6 sets once a command frame has been sent. Frames without a command carry tag 16'h8000 and zero slots.
- R5: Any read or write access to 0x80 or 0x84 clears raw status bits 1 and 6. Reading 0x8C does not clear them.
- R6: An incoming frame with tag bit 15 set sets raw status bit 5. A rising edge on `codec_wake_i` sets raw bit 0. Writing 0x98 with bit 1 set clears bit 5, and writing it with bit 0 set clears bit 0. Each clear leaves the other bit unchanged.
- R7: Register 0x90 reads raw status ANDed with the mask at 0x94. `irq_o` is high one cycle after that AND is nonzero and low otherwise.
- R8: While bit 0 of 0x9C is 0, no frames are sent, incoming frames are ignored, and a command launched in that time is dropped. Setting the bit resumes idle frames.
- R9: Writing bit 0 of 0xA0 drives `codec_reset_o` high for exactly COLD_CYCLES cycles. Writing bit 0 of 0xA4 drives `sync_pulse_o` high for exactly WARM_CYCLES cycles. A request made while that pulse is running is ignored.
- R10: After reset, all outputs are 0, all status bits are 0, and the link is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, one cycle after access |
| irq_o | output | 1 | Level-high interrupt |
| tx_valid_o | output | 1 | One-cycle strobe per outgoing frame |
| tx_tag_o | output | 16 | Outgoing slot-0 tag |
| tx_slot1_o | output | 20 | Outgoing command address slot |
| tx_slot2_o | output | 20 | Outgoing command data slot |
| rx_valid_i | input | 1 | One-cycle strobe per incoming frame |
| rx_tag_i | input | 16 | Incoming slot-0 tag |
| rx_slot2_i | input | 20 | Incoming status data slot |
| codec_wake_i | input | 1 | Codec wake request level |
| codec_reset_o | output | 1 | Cold-reset pulse to codec |
| sync_pulse_o | output | 1 | Warm-reset SYNC pulse |

## Verification
The bench targets several corner cases in read/write selection and status handling.

- Read versus write must be decided by whether slot 2 was loaded since the last command. A design that remembered slot 2 forever would send later reads as writes.
- A stray codec reply must be ignored. A design that accepted it would overwrite the read data when no read is outstanding.
- The two end-of-interrupt bits must clear independently. A design that cleared both together would lose the wake bit.
- Disabling the link must drop a pending command. A design that kept it would fire that command when the link is enabled again.
- A pulse request during a running pulse must be ignored. A retriggerable timer would stretch the pulse beyond its cycle count.

// File: rtl/ac97_cmd_pkg.sv
package ac97_cmd_pkg;
  localparam int IDX_W  = 7;
  localparam int CDAT_W = 16;
  localparam int SLOT_W = 20;
  localparam int TAG_W  = 16;
  localparam int STAT_W = 7;

  localparam logic [7:0] A_SLOT1 = 8'h80;
  localparam logic [7:0] A_SLOT2 = 8'h84;
  localparam logic [7:0] A_RAW   = 8'h8C;
  localparam logic [7:0] A_MSK_S = 8'h90;
  localparam logic [7:0] A_MASK  = 8'h94;
  localparam logic [7:0] A_EOI   = 8'h98;
  localparam logic [7:0] A_CTRL  = 8'h9C;
  localparam logic [7:0] A_COLD  = 8'hA0;
  localparam logic [7:0] A_WARM  = 8'hA4;

  localparam int B_WAKE = 0;
  localparam int B_RXV  = 1;
  localparam int B_RDY  = 5;
  localparam int B_TXD  = 6;

  localparam int T_FRAME = 15;
  localparam int T_S1    = 14;
  localparam int T_S2    = 13;
endpackage

// File: rtl/ac97_pulse_timer.sv
module ac97_pulse_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic pulse_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      cnt_q   <= '0;
    end else if (!pulse_o) begin
      if (start_i) begin
        pulse_o <= 1'b1;
        cnt_q   <= LOAD;
      end
    end else if (cnt_q == '0) begin
      pulse_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ac97_frame_gen.sv
module ac97_frame_gen
  import ac97_cmd_pkg::*;
#(
  parameter int FRAME_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              cmd_pend_i,
  input  logic              cmd_read_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic [CDAT_W-1:0] cmd_data_i,
  output logic              tx_valid_o,
  output logic [TAG_W-1:0]  tx_tag_o,
  output logic [SLOT_W-1:0] tx_slot1_o,
  output logic [SLOT_W-1:0] tx_slot2_o,
  output logic              cmd_sent_o
);
  localparam int CW = $clog2(FRAME_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(FRAME_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          tick;
  logic          has_wr;

  assign tick   = en_i && (cnt_q == LAST);
  assign has_wr = cmd_pend_i && !cmd_read_i;

  always_ff @(posedge clk) begin
    if (rst || !en_i) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid_o <= 1'b0;
      tx_tag_o   <= '0;
      tx_slot1_o <= '0;
      tx_slot2_o <= '0;
      cmd_sent_o <= 1'b0;
    end else begin
      tx_valid_o <= tick;
      cmd_sent_o <= tick && cmd_pend_i;
      if (tick) begin
        tx_tag_o          <= '0;
        tx_tag_o[T_FRAME] <= 1'b1;
        tx_tag_o[T_S1]    <= cmd_pend_i;
        tx_tag_o[T_S2]    <= has_wr;
        tx_slot1_o        <= cmd_pend_i ? {cmd_read_i, cmd_idx_i, 12'h000} : '0;
        tx_slot2_o        <= has_wr ? {cmd_data_i, 4'h0} : '0;
      end
    end
  end
endmodule

// File: rtl/ac97_cmd_regs.sv
module ac97_cmd_regs
  import ac97_cmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  input  logic              rx_valid_i,
  input  logic [TAG_W-1:0]  rx_tag_i,
  input  logic [SLOT_W-1:0] rx_slot2_i,
  input  logic              codec_wake_i,
  input  logic              cmd_sent_i,
  output logic              en_o,
  output logic              cmd_pend_o,
  output logic              cmd_read_o,
  output logic [IDX_W-1:0]  cmd_idx_o,
  output logic [CDAT_W-1:0] cmd_data_o,
  output logic              cold_start_o,
  output logic              warm_start_o
);
  logic [STAT_W-1:0] raw_q, mask_q, raw_v;
  logic              s2_loaded_q, await_q, wake_q;
  logic              wr, rd, acc_slot;
  logic [7:0]        a8;
  logic [DATA_W-1:0] rmux;

  assign a8       = 8'(bus_addr_i);
  assign wr       = bus_sel_i && bus_wr_i;
  assign rd       = bus_sel_i && !bus_wr_i;
  assign acc_slot = bus_sel_i && (a8 == A_SLOT1 || a8 == A_SLOT2);
  assign raw_v    = raw_q;

  assign cold_start_o = wr && (a8 == A_COLD) && bus_wdata_i[0];
  assign warm_start_o = wr && (a8 == A_WARM) && bus_wdata_i[0];

  always_comb begin
    rmux = '0;
    case (a8)
      A_SLOT1: rmux = DATA_W'(cmd_idx_o);
      A_SLOT2: rmux = DATA_W'(cmd_data_o);
      A_RAW:   rmux = DATA_W'(raw_v);
      A_MSK_S: rmux = DATA_W'(raw_v & mask_q);
      A_MASK:  rmux = DATA_W'(mask_q);
      A_CTRL:  rmux = DATA_W'(en_o);
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
      irq_o       <= 1'b0;
      raw_q       <= '0;
      mask_q      <= '0;
      en_o        <= 1'b0;
      cmd_pend_o  <= 1'b0;
      cmd_read_o  <= 1'b0;
      cmd_idx_o   <= '0;
      cmd_data_o  <= '0;
      s2_loaded_q <= 1'b0;
      await_q     <= 1'b0;
      wake_q      <= 1'b0;
    end else begin
      wake_q <= codec_wake_i;
      irq_o  <= |(raw_q & mask_q);
      if (rd) bus_rdata_o <= rmux;
      if (wr && a8 == A_CTRL) en_o <= bus_wdata_i[0];
      if (wr && a8 == A_MASK) mask_q <= bus_wdata_i[STAT_W-1:0];
      if (wr && a8 == A_SLOT2) begin
        cmd_data_o  <= bus_wdata_i[CDAT_W-1:0];
        s2_loaded_q <= 1'b1;
      end
      if (cmd_sent_i) begin
        cmd_pend_o <= 1'b0;
        if (cmd_read_o) await_q <= 1'b1;
      end
      if (wr && a8 == A_SLOT1) begin
        cmd_idx_o   <= bus_wdata_i[IDX_W-1:0];
        cmd_pend_o  <= 1'b1;
        cmd_read_o  <= !s2_loaded_q;
        s2_loaded_q <= 1'b0;
        await_q     <= 1'b0;
      end
      if (acc_slot) begin
        raw_q[B_RXV] <= 1'b0;
        raw_q[B_TXD] <= 1'b0;
      end
      if (cmd_sent_i) raw_q[B_TXD] <= 1'b1;
      if (en_o && rx_valid_i) begin
        if (rx_tag_i[T_FRAME]) raw_q[B_RDY] <= 1'b1;
        if (await_q && rx_tag_i[T_S2]) begin
          cmd_data_o   <= rx_slot2_i[SLOT_W-1:4];
          raw_q[B_RXV] <= 1'b1;
          await_q      <= 1'b0;
        end
      end
      if (wr && a8 == A_EOI) begin
        if (bus_wdata_i[1]) raw_q[B_RDY]  <= 1'b0;
        if (bus_wdata_i[0]) raw_q[B_WAKE] <= 1'b0;
      end
      if (codec_wake_i && !wake_q) raw_q[B_WAKE] <= 1'b1;
      if (!en_o) begin
        cmd_pend_o <= 1'b0;
        await_q    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ac97_cmd_engine.sv
module ac97_cmd_engine
  import ac97_cmd_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32,
  parameter int FRAME_CYCLES = 32,
  parameter int COLD_CYCLES  = 40,
  parameter int WARM_CYCLES  = 240
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              tx_valid_o,
  output logic [15:0]       tx_tag_o,
  output logic [19:0]       tx_slot1_o,
  output logic [19:0]       tx_slot2_o,
  input  logic              rx_valid_i,
  input  logic [15:0]       rx_tag_i,
  input  logic [19:0]       rx_slot2_i,
  input  logic              codec_wake_i,
  output logic              codec_reset_o,
  output logic              sync_pulse_o
);
  logic              link_en, cmd_pend, cmd_read, cmd_sent;
  logic              cold_start, warm_start;
  logic [IDX_W-1:0]  cmd_idx;
  logic [CDAT_W-1:0] cmd_data;

  ac97_cmd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst),
    .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o),
    .rx_valid_i(rx_valid_i), .rx_tag_i(rx_tag_i), .rx_slot2_i(rx_slot2_i),
    .codec_wake_i(codec_wake_i), .cmd_sent_i(cmd_sent),
    .en_o(link_en), .cmd_pend_o(cmd_pend), .cmd_read_o(cmd_read),
    .cmd_idx_o(cmd_idx), .cmd_data_o(cmd_data),
    .cold_start_o(cold_start), .warm_start_o(warm_start)
  );

  ac97_frame_gen #(.FRAME_CYCLES(FRAME_CYCLES)) frame_i (
    .clk(clk), .rst(rst), .en_i(link_en),
    .cmd_pend_i(cmd_pend), .cmd_read_i(cmd_read),
    .cmd_idx_i(cmd_idx), .cmd_data_i(cmd_data),
    .tx_valid_o(tx_valid_o), .tx_tag_o(tx_tag_o),
    .tx_slot1_o(tx_slot1_o), .tx_slot2_o(tx_slot2_o),
    .cmd_sent_o(cmd_sent)
  );

  ac97_pulse_timer #(.CYCLES(COLD_CYCLES)) cold_i (
    .clk(clk), .rst(rst), .start_i(cold_start), .pulse_o(codec_reset_o)
  );

  ac97_pulse_timer #(.CYCLES(WARM_CYCLES)) warm_i (
    .clk(clk), .rst(rst), .start_i(warm_start), .pulse_o(sync_pulse_o)
  );
endmodule

// File: rtl/ac97_cmd_engine_chk.sv
module ac97_cmd_engine_chk #(
  parameter int COLD_CYCLES = 40,
  parameter int WARM_CYCLES = 240
) (
  input logic        clk,
  input logic        rst,
  input logic        link_en,
  input logic        tx_valid_o,
  input logic [15:0] tx_tag_o,
  input logic [19:0] tx_slot1_o,
  input logic [19:0] tx_slot2_o,
  input logic        codec_reset_o,
  input logic        sync_pulse_o
);
  logic [31:0] cold_cnt, warm_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cold_cnt <= '0;
      warm_cnt <= '0;
    end else begin
      cold_cnt <= codec_reset_o ? cold_cnt + 1 : '0;
      warm_cnt <= sync_pulse_o ? warm_cnt + 1 : '0;
    end
  end

  p_write_frame_r1: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && tx_tag_o[13]) |-> (tx_tag_o[14] && !tx_slot1_o[19]));

  p_read_frame_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && tx_tag_o[14] && !tx_tag_o[13]) |-> (tx_slot1_o[19] && tx_slot2_o == 20'h0));

  p_idle_frame_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && !tx_tag_o[14]) |-> (tx_tag_o == 16'h8000 && tx_slot1_o == 20'h0 && tx_slot2_o == 20'h0));

  p_frame_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |=> !tx_valid_o);

  p_no_frame_off_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(link_en) |-> !tx_valid_o);

  p_cold_width_r9: assert property (@(posedge clk) disable iff (rst)
    codec_reset_o |-> (cold_cnt < COLD_CYCLES));

  p_warm_width_r9: assert property (@(posedge clk) disable iff (rst)
    sync_pulse_o |-> (warm_cnt < WARM_CYCLES));
endmodule

bind ac97_cmd_engine ac97_cmd_engine_chk #(
  .COLD_CYCLES(COLD_CYCLES), .WARM_CYCLES(WARM_CYCLES)
) chk_i (
  .clk(clk), .rst(rst), .link_en(link_en),
  .tx_valid_o(tx_valid_o), .tx_tag_o(tx_tag_o),
  .tx_slot1_o(tx_slot1_o), .tx_slot2_o(tx_slot2_o),
  .codec_reset_o(codec_reset_o), .sync_pulse_o(sync_pulse_o)
);

// File: tb/ac97_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module ac97_cmd_engine_tb_top;
  localparam int FRAME = 32;
  localparam int COLD  = 40;
  localparam int WARM  = 240;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        irq, tx_valid, rx_valid = 0, wake = 0, cold, sync;
  logic [15:0] tx_tag, rx_tag = 0;
  logic [19:0] tx_s1, tx_s2, rx_s2 = 0;

  int tests = 0, fails = 0;
  logic [31:0] rv;
  bit found;

  always #2.5 clk = ~clk;

  ac97_cmd_engine #(.FRAME_CYCLES(FRAME), .COLD_CYCLES(COLD), .WARM_CYCLES(WARM)) dut_i (
    .clk(clk), .rst(rst), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .tx_valid_o(tx_valid), .tx_tag_o(tx_tag),
    .tx_slot1_o(tx_s1), .tx_slot2_o(tx_s2), .rx_valid_i(rx_valid),
    .rx_tag_i(rx_tag), .rx_slot2_i(rx_s2), .codec_wake_i(wake),
    .codec_reset_o(cold), .sync_pulse_o(sync)
  );

  // {index[6:0], data[15:0]}
  localparam logic [22:0] VEC [4] = '{
    {7'h02, 16'h8000}, {7'h18, 16'h0808}, {7'h7E, 16'hFFFF}, {7'h00, 16'h1234}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_frame(input bit want_cmd, output bit ok);
    ok = 0;
    for (int i = 0; i < 4 * FRAME; i++) begin
      @(negedge clk);
      if (tx_valid && (tx_tag[14] == want_cmd)) begin
        ok = 1;
        break;
      end
    end
  endtask

  task automatic rx_frame(input logic [15:0] tag, input logic [19:0] s2);
    @(negedge clk);
    rx_valid = 1; rx_tag = tag; rx_s2 = s2;
    @(negedge clk);
    rx_valid = 0; rx_tag = 0; rx_s2 = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cnt;
    repeat (5) @(negedge clk);
    rst = 0;
    // R10: reset state
    chk("R10 outputs", {28'h0, irq, tx_valid, cold, sync}, 32'h0);
    bus_read(8'h8C, rv); chk("R10 raw", rv, 32'h0);
    bus_read(8'h9C, rv); chk("R10 enable", rv, 32'h0);

    bus_write(8'h9C, 32'h1);
    wait_frame(0, found); chk("R4 idle frame seen", {31'h0, found}, 32'h1);
    chk("R4 idle tag", {16'h0, tx_tag}, 32'h8000);
    chk("R4 idle slots", {12'h0, tx_s1 | tx_s2}, 32'h0);

    // R6: codec ready from incoming tag
    rx_frame(16'h8000, 20'h0); idle(2);
    bus_read(8'h8C, rv); chk("R6 ready set", rv, 32'h20);
    bus_write(8'h98, 32'h2);
    bus_read(8'h8C, rv); chk("R6 ready cleared", rv, 32'h0);

    // R1/R4/R5: table of codec writes
    for (int v = 0; v < 4; v++) begin
      bus_write(8'h84, {16'h0, VEC[v][15:0]});
      bus_write(8'h80, {25'h0, VEC[v][22:16]});
      wait_frame(1, found); chk("R1 cmd frame seen", {31'h0, found}, 32'h1);
      chk("R1 tag", {16'h0, tx_tag}, 32'hE000);
      chk("R1 slot1", {12'h0, tx_s1}, {12'h0, 1'b0, VEC[v][22:16], 12'h000});
      chk("R1 slot2", {12'h0, tx_s2}, {12'h0, VEC[v][15:0], 4'h0});
      idle(2);
      bus_read(8'h8C, rv); chk("R4 txdone", rv, 32'h40);
      bus_read(8'h80, rv); chk("R5 slot1 readback", rv, {25'h0, VEC[v][22:16]});
      bus_read(8'h8C, rv); chk("R5 slot1 access clears", rv, 32'h0);
    end

    // R2/R3: codec read
    bus_write(8'h80, 32'h26);
    wait_frame(1, found); chk("R2 read frame seen", {31'h0, found}, 32'h1);
    chk("R2 tag", {16'h0, tx_tag}, 32'hC000);
    chk("R2 slot1", {12'h0, tx_s1}, {12'h0, 1'b1, 7'h26, 12'h000});
    chk("R2 slot2", {12'h0, tx_s2}, 32'h0);
    idle(3);
    rx_frame(16'hE000, {16'hBEEF, 4'h0}); idle(2);
    bus_read(8'h8C, rv); chk("R3 rxvalid", rv, 32'h62);
    bus_read(8'h84, rv); chk("R3 read data", rv, 32'hBEEF);
    bus_read(8'h8C, rv); chk("R5 slot2 access clears", rv, 32'h20);
    bus_write(8'h98, 32'h2);
    rx_frame(16'hE000, {16'h1234, 4'h0}); idle(2);
    bus_read(8'h84, rv); chk("R3 stray reply ignored", rv, 32'hBEEF);
    bus_read(8'h8C, rv); chk("R3 stray no rxvalid", rv, 32'h20);
    bus_write(8'h98, 32'h2);

    // R7: interrupt masking
    bus_write(8'h94, 32'h40);
    bus_write(8'h84, 32'h5555);
    bus_write(8'h80, 32'h10);
    wait_frame(1, found); idle(3);
    chk("R7 irq high", {31'h0, irq}, 32'h1);
    bus_read(8'h90, rv); chk("R7 masked status", rv, 32'h40);
    bus_read(8'h84, rv); idle(2);
    chk("R7 irq low after ack", {31'h0, irq}, 32'h0);
    bus_write(8'h94, 32'h0);
    bus_write(8'h84, 32'h5555);
    bus_write(8'h80, 32'h10);
    wait_frame(1, found); idle(3);
    chk("R7 irq masked off", {31'h0, irq}, 32'h0);
    bus_read(8'h90, rv); chk("R7 masked zero", rv, 32'h0);
    bus_read(8'h8C, rv); chk("R7 raw still set", rv, 32'h40);
    bus_read(8'h80, rv);

    // R6: wake and independent EOI bits
    @(negedge clk); wake = 1; idle(2);
    bus_read(8'h8C, rv); chk("R6 wake set", rv, 32'h01);
    bus_write(8'h98, 32'h2);
    bus_read(8'h8C, rv); chk("R6 ready-EOI keeps wake", rv, 32'h01);
    bus_write(8'h98, 32'h1);
    bus_read(8'h8C, rv); chk("R6 wake cleared", rv, 32'h0);
    wake = 0;

    // R8: disable drops frames, rx and pending command
    bus_write(8'h9C, 32'h0);
    bus_write(8'h84, 32'hAAAA);
    bus_write(8'h80, 32'h22);
    rx_frame(16'h8000, 20'h0);
    cnt = 0;
    for (int i = 0; i < 3 * FRAME; i++) begin
      @(negedge clk);
      if (tx_valid) cnt++;
    end
    chk("R8 no frames when off", cnt, 0);
    bus_read(8'h8C, rv); chk("R8 rx ignored when off", rv, 32'h0);
    bus_write(8'h9C, 32'h1);
    found = 0;
    for (int i = 0; i < 4 * FRAME; i++) begin
      @(negedge clk);
      if (tx_valid) begin found = 1; break; end
    end
    chk("R8 resumes", {31'h0, found}, 32'h1);
    chk("R8 dropped command", {16'h0, tx_tag}, 32'h8000);

    // R9: cold pulse with retrigger attempt
    bus_write(8'hA0, 32'h1);
    cnt = cold ? 1 : 0;
    for (int i = 1; i < 400; i++) begin
      @(negedge clk);
      if (i == 3) begin bus_sel = 1; bus_wr = 1; bus_addr = 8'hA0; bus_wdata = 1; end
      if (i == 4) begin bus_sel = 0; bus_wr = 0; end
      if (cold) cnt++; else break;
    end
    chk("R9 cold width", cnt, COLD);
    chk("R9 sync idle during cold", {31'h0, sync}, 32'h0);
    bus_write(8'hA4, 32'h1);
    cnt = sync ? 1 : 0;
    for (int i = 1; i < 600; i++) begin
      @(negedge clk);
      if (sync) cnt++; else break;
    end
    chk("R9 warm width", cnt, WARM);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule